// File: doc/BRIEF.md
# Flag-Coupled Loop Counter Unit

This block keeps the outer loop counter of an instruction-executing unit together with the zero flag tied to it, plus a separate inner loop counter. Commands arrive as a strobe with an opcode and a load value. The unit may load the outer counter, decrement it, or copy either counter into the low bits of a wider data word (the data latch). The zero flag is not a separate storage bit. It is decoded all the time from the outer counter, so the two can never disagree.

The outer counter can only be loaded while it is empty. It can only be decremented while the externally supplied D flag is clear. A command refused under these predicates is dropped, and the unit raises a one-cycle skip pulse. The sequencer upstream treats that pulse as "instruction did not execute". A decrement of an empty counter stays at zero.

Commands are control strobes and are never back-pressured: every strobe is acted on in the cycle it is presented. The latch result is a registered word that comes with a one-cycle valid pulse. The consumer must take it in that cycle, because there is no ready input and the word is held only until the next read-out overwrites it.

Top module: `loopctr_unit`

## Requirements
- R1: `zero_flag` is 1 exactly when `octr_out` is 0, in every cycle.
- R2: A strobe with opcode 1 (outer load) while `zero_flag` is 1 makes `octr_out` equal `cmd_val[OW-1:0]` from the next cycle, with `skip_pulse` 0.
- R3: An outer load while `zero_flag` is 0 leaves `octr_out` unchanged and raises `skip_pulse` for exactly the next cycle.
- R4: A strobe with opcode 2 (outer decrement) with `dflag` 0 and a nonzero counter lowers `octr_out` by one in the next cycle, with `skip_pulse` 0.
- R5: An outer decrement with `dflag` 1 leaves `octr_out` unchanged and raises `skip_pulse` for the next cycle.
- R6: An outer decrement with `dflag` 0 while the counter is 0 keeps it at 0, keeps `zero_flag` at 1 and does not raise `skip_pulse`.
- R7: A strobe with opcode 3 (outer read-out) makes `latch_out` equal `latch_in` with bits [OW-1:0] replaced by the outer counter, and raises `latch_vld` for one cycle. `latch_out` holds its value otherwise.
- R8: Opcode 4 loads the inner counter from `cmd_val[IW-1:0]` unconditionally. Opcode 5 replaces bits [IW-1:0] of `latch_in` with the inner counter into `latch_out`, with a one-cycle `latch_vld`.
- R9: While `rst_n` is 0, both counters are 0, `zero_flag` is 1, and `skip_pulse`, `latch_vld` and `latch_out` are 0.
- R10: Opcodes 0, 6 and 7, and any cycle with `cmd_vld` 0, change no counter and raise neither `skip_pulse` nor `latch_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_vld | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode |
| cmd_val | input | max(OW,IW) | Load value |
| dflag | input | 1 | D flag; blocks outer decrements when 1 |
| skip_pulse | output | 1 | One-cycle pulse for a refused command |
| zero_flag | output | 1 | Outer counter is zero |
| octr_out | output | OW | Outer counter |
| ictr_out | output | IW | Inner counter |
| latch_in | input | DW | Data latch word to merge into |
| latch_out | output | DW | Merged latch word |
| latch_vld | output | 1 | One-cycle valid for `latch_out` |

## Verification
The bench builds the unit with OW=4, IW=3 and DW=12, so random loads and decrements sweep the whole outer range, including the maximum value and zero, within a few hundred commands. The outer and inner widths differ, so a read-out that inserts the wrong number of bits or pulls from the wrong counter shows up in the latch word. Refused loads, refused decrements, decrements at zero and unused opcodes are each driven in a directed sequence and then mixed at random against the behavioural model.

// File: rtl/loopctr_pkg.sv
package loopctr_pkg;
  localparam int OP_W = 3;
  typedef enum logic [OP_W-1:0] {
    OP_IDLE  = 3'd0,
    OP_OLOAD = 3'd1,
    OP_ODEC  = 3'd2,
    OP_OREAD = 3'd3,
    OP_ILOAD = 3'd4,
    OP_IREAD = 3'd5
  } lc_op_e;
endpackage

// File: rtl/loopctr_outer.sv
module loopctr_outer #(
  parameter int OW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req,
  input  logic          dec_req,
  input  logic          dflag,
  input  logic [OW-1:0] load_val,
  output logic [OW-1:0] count,
  output logic          zero,
  output logic          skip
);
  logic [OW-1:0] count_q, count_d;
  logic          skip_d, skip_q;
  logic          empty;

  // zero flag is decoded from the counter, never stored on its own
  assign empty = (count_q == '0);

  always_comb begin
    count_d = count_q;
    skip_d  = 1'b0;
    if (load_req) begin
      if (empty) count_d = load_val;
      else       skip_d  = 1'b1;
    end else if (dec_req) begin
      if (dflag)       skip_d  = 1'b1;
      else if (!empty) count_d = count_q - OW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      skip_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      skip_q  <= skip_d;
    end
  end

  assign count = count_q;
  assign zero  = empty;
  assign skip  = skip_q;
endmodule

// File: rtl/loopctr_inner.sv
module loopctr_inner #(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req,
  input  logic [IW-1:0] load_val,
  output logic [IW-1:0] count
);
  logic [IW-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (load_req) count_q <= load_val;
  end

  assign count = count_q;
endmodule

// File: rtl/loopctr_insert.sv
module loopctr_insert #(
  parameter int DW = 37,
  parameter int OW = 6,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_outer,
  input  logic          sel_inner,
  input  logic [DW-1:0] word_in,
  input  logic [OW-1:0] ocount,
  input  logic [IW-1:0] icount,
  output logic [DW-1:0] word_out,
  output logic          word_vld
);
  logic [DW-1:0] merged;
  logic [DW-1:0] word_q;
  logic          vld_q;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    logic from_o, from_i;
    if (b < OW) begin : g_o
      assign from_o = sel_outer;
    end else begin : g_no
      assign from_o = 1'b0;
    end
    if (b < IW) begin : g_i
      assign from_i = sel_inner;
    end else begin : g_ni
      assign from_i = 1'b0;
    end
    if (b < OW && b < IW) begin : g_both
      assign merged[b] = from_o ? ocount[b] : (from_i ? icount[b] : word_in[b]);
    end else if (b < OW) begin : g_oonly
      assign merged[b] = from_o ? ocount[b] : word_in[b];
    end else if (b < IW) begin : g_ionly
      assign merged[b] = from_i ? icount[b] : word_in[b];
    end else begin : g_pass
      assign merged[b] = word_in[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= sel_outer | sel_inner;
      if (sel_outer | sel_inner) word_q <= merged;
    end
  end

  assign word_out = word_q;
  assign word_vld = vld_q;
endmodule

// File: rtl/loopctr_unit.sv
module loopctr_unit
  import loopctr_pkg::*;
#(
  parameter int DW = 37,
  parameter int OW = 6,
  parameter int IW = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cmd_vld,
  input  logic [2:0]                      cmd_op,
  input  logic [((OW > IW) ? OW : IW)-1:0] cmd_val,
  input  logic                            dflag,
  output logic                            skip_pulse,
  output logic                            zero_flag,
  output logic [OW-1:0]                   octr_out,
  output logic [IW-1:0]                   ictr_out,
  input  logic [DW-1:0]                   latch_in,
  output logic [DW-1:0]                   latch_out,
  output logic                            latch_vld
);
  logic do_oload, do_odec, do_oread, do_iload, do_iread;

  always_comb begin
    do_oload = cmd_vld && (cmd_op == OP_OLOAD);
    do_odec  = cmd_vld && (cmd_op == OP_ODEC);
    do_oread = cmd_vld && (cmd_op == OP_OREAD);
    do_iload = cmd_vld && (cmd_op == OP_ILOAD);
    do_iread = cmd_vld && (cmd_op == OP_IREAD);
  end

  loopctr_outer #(.OW(OW)) outer_i (
    .clk(clk), .rst_n(rst_n), .load_req(do_oload), .dec_req(do_odec),
    .dflag(dflag), .load_val(cmd_val[OW-1:0]), .count(octr_out),
    .zero(zero_flag), .skip(skip_pulse)
  );

  loopctr_inner #(.IW(IW)) inner_i (
    .clk(clk), .rst_n(rst_n), .load_req(do_iload),
    .load_val(cmd_val[IW-1:0]), .count(ictr_out)
  );

  loopctr_insert #(.DW(DW), .OW(OW), .IW(IW)) insert_i (
    .clk(clk), .rst_n(rst_n), .sel_outer(do_oread), .sel_inner(do_iread),
    .word_in(latch_in), .ocount(octr_out), .icount(ictr_out),
    .word_out(latch_out), .word_vld(latch_vld)
  );
endmodule

// File: rtl/loopctr_unit_chk.sv
module loopctr_unit_chk #(
  parameter int DW = 37,
  parameter int OW = 6,
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_vld,
  input logic [2:0]    cmd_op,
  input logic          dflag,
  input logic          skip_pulse,
  input logic          zero_flag,
  input logic [OW-1:0] octr_out,
  input logic [IW-1:0] ictr_out,
  input logic [DW-1:0] latch_in,
  input logic [DW-1:0] latch_out,
  input logic          latch_vld
);
  a_r1_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    zero_flag == (octr_out == '0));

  a_r3_load_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == 3'd1 && !zero_flag) |=> ($stable(octr_out) && skip_pulse));

  a_r4_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == 3'd2 && !dflag && !zero_flag)
      |=> (octr_out == OW'($past(octr_out) - OW'(1)) && !skip_pulse));

  a_r5_dec_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == 3'd2 && dflag) |=> ($stable(octr_out) && skip_pulse));

  a_r6_dec_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == 3'd2 && !dflag && zero_flag) |=> (zero_flag && !skip_pulse));

  a_r7_oread_merge: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == 3'd3)
      |=> (latch_vld && latch_out[OW-1:0] == $past(octr_out)
           && latch_out[DW-1:OW] == $past(latch_in[DW-1:OW])));

  a_r8_iread_merge: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_op == 3'd5)
      |=> (latch_vld && latch_out[IW-1:0] == $past(ictr_out)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_vld || cmd_op == 3'd0 || cmd_op > 3'd5)
      |=> ($stable(octr_out) && $stable(ictr_out) && !skip_pulse && !latch_vld));
endmodule

bind loopctr_unit loopctr_unit_chk #(.DW(DW), .OW(OW), .IW(IW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op), .dflag(dflag),
  .skip_pulse(skip_pulse), .zero_flag(zero_flag), .octr_out(octr_out),
  .ictr_out(ictr_out), .latch_in(latch_in), .latch_out(latch_out),
  .latch_vld(latch_vld)
);

// File: tb/loopctr_unit_tb_top.sv
module loopctr_unit_tb_top;
  localparam int DW = 12;
  localparam int OW = 4;
  localparam int IW = 3;
  localparam int VW = (OW > IW) ? OW : IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_vld = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [VW-1:0] cmd_val = '0;
  logic          dflag = 1'b0;
  logic          skip_pulse, zero_flag, latch_vld;
  logic [OW-1:0] octr_out;
  logic [IW-1:0] ictr_out;
  logic [DW-1:0] latch_in = '0;
  logic [DW-1:0] latch_out;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  int            m_oc = 0, m_ic = 0;
  bit            m_skip = 0, m_lv = 0;
  logic [DW-1:0] m_lat = '0;
  string         tag = "R9";

  always #2.5 clk = ~clk;

  loopctr_unit #(.DW(DW), .OW(OW), .IW(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_val(cmd_val), .dflag(dflag), .skip_pulse(skip_pulse),
    .zero_flag(zero_flag), .octr_out(octr_out), .ictr_out(ictr_out),
    .latch_in(latch_in), .latch_out(latch_out), .latch_vld(latch_vld)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(tag, "octr", octr_out, m_oc);
    chk("R1", "zero", zero_flag, (m_oc == 0));
    chk(tag, "ictr", ictr_out, m_ic);
    chk(tag, "skip", skip_pulse, m_skip);
    chk(tag, "lvld", latch_vld, m_lv);
    chk(tag, "latch", latch_out, m_lat);
  endtask

  // compare the results of the previous command, then apply a new one
  task automatic step(input bit v, input int op, input int val, input bit d, input logic [DW-1:0] lat);
    int omask = (1 << OW) - 1;
    int imask = (1 << IW) - 1;
    @(negedge clk);
    compare_all();
    m_skip = 0;
    m_lv   = 0;
    tag    = "R10";
    if (v) begin
      case (op)
        1: begin
          tag = (m_oc == 0) ? "R2" : "R3";
          if (m_oc == 0) m_oc = val & omask; else m_skip = 1;
        end
        2: begin
          tag = d ? "R5" : ((m_oc == 0) ? "R6" : "R4");
          if (d) m_skip = 1; else if (m_oc != 0) m_oc = m_oc - 1;
        end
        3: begin
          tag = "R7";
          m_lat = (lat & ~DW'(omask)) | DW'(m_oc);
          m_lv = 1;
        end
        4: begin tag = "R8"; m_ic = val & imask; end
        5: begin
          tag = "R8";
          m_lat = (lat & ~DW'(imask)) | DW'(m_ic);
          m_lv = 1;
        end
        default: tag = "R10";
      endcase
    end
    cmd_vld  = v;
    cmd_op   = 3'(op);
    cmd_val  = VW'(val);
    dflag    = d;
    latch_in = lat;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all(); // R9 reset state while held
    rst_n = 1'b1;
    // directed sequence
    step(1, 2, 0, 0, 12'hABC);   // R6 decrement at zero
    step(1, 1, 5, 0, 12'h000);   // R2 load when empty
    step(1, 1, 3, 0, 12'h000);   // R3 load refused
    step(1, 2, 0, 1, 12'h000);   // R5 decrement refused
    for (int k = 0; k < 5; k++) step(1, 2, 0, 0, 12'h000); // R4 down to zero
    step(1, 1, 15, 0, 12'h000);  // R2 load maximum
    step(1, 3, 0, 0, 12'hFA5);   // R7 outer read-out
    step(1, 4, 6, 0, 12'h000);   // R8 inner load
    step(1, 5, 0, 0, 12'h3C3);   // R8 inner read-out
    step(1, 6, 1, 0, 12'h111);   // R10 unused code
    step(1, 7, 1, 1, 12'h222);   // R10 unused code
    step(0, 1, 1, 0, 12'h333);   // R10 strobe low
    step(1, 0, 2, 0, 12'h444);   // R10 idle code
    for (int k = 0; k < 3000; k++)
      step($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 15),
           $urandom_range(0, 3) == 0, DW'($urandom));
    step(0, 0, 0, 0, '0);
    @(negedge clk);
    compare_all();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule